// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks the element loop of one vector operation and issues pairs of element indices, one from the source side and one from the destination side, to a datapath that sits downstream. Each side has its own predicate mask. Because the two masks are applied independently, the same walk can pack selected sources into adjacent destinations (compress), spread adjacent sources over selected destinations (expand), or do both at once.

A `start` pulse captures the vector length, the two stored step counters and both masks, which are built from an integer register value, its complement, a one-hot bit selected by a register value, or per-element equal bits of a condition field array. Issued pairs leave on a valid/ready stream. `iss_valid` stays high and the pair on `iss_src_idx`, `iss_dst_idx`, `iss_we` and `iss_zero` stays unchanged until `iss_ready` accepts it. The one exception is `pause`, which withdraws the offer at an operation boundary. `pause` stops the loop with its step counters visible on the step outputs, so the loop can be resumed later from those values. When the loop ends normally, `done` pulses and both step counters return to zero.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `busy`, `iss_valid` and `done` are 0 and both step outputs are 0.
- R2: For each pair, the source position is the first element at or after the source step whose source mask bit is 1. The destination position is the first such element at or after the destination step in the destination mask. When the pair is accepted, each step moves to its position plus one. `iss_we`=1 and `iss_zero`=0 for such a pair.
- R3: With a source mask and an all-ones destination mask, the selected sources are issued to destinations 0, 1, 2 and so on (compress).
- R4: With an all-ones source mask and a destination mask, sources 0, 1, 2 and so on are issued to the selected destinations (expand).
- R5: The loop ends as soon as either position reaches the vector length, and the elements left on the other side are never issued. In the next cycle `done` is 1 for exactly one cycle, `busy` is 0 and both steps read 0.
- R6: A vector length of 0 issues no pair and still produces `done`.
- R7: With `zero_dst`=1, a destination element whose mask bit is 0 is not skipped. It is issued with `iss_zero`=1 and `iss_we`=0. The destination step advances by one and the source step stays where it is.
- R8: Mask mode codes: 0 gives all ones. 1 gives the register value taken as it is. 2 gives its bitwise complement. 3 gives a one-hot mask equal to 1 shifted left by the register value, which is all zeros if the value is 128 or more. Modes 6 and 7 behave as mode 0. Register-based masks cover elements 0 to 63; higher elements read 0.
- R9: Mode 4 sets mask bit i to `cr_eq[base+i]`. Mode 5 sets it to the inverse of that bit. The base is the side's `*_cr_base` input, and an index past the array reads as 0 in both modes.
- R10: The loop starts from `src_step_in` and `dst_step_in`, so a nonzero pair of steps resumes an interrupted walk.
- R11: With `dst_scalar`=1, the loop ends after the first accepted pair.
- R12: When `pause` is high in a running loop, no pair is offered and the loop stops on the next edge without `done`. The step outputs then hold the position of the next pair to issue.
- R13: While `iss_valid`=1 and `iss_ready`=0, the offered pair stays unchanged in the next cycle unless `pause` is high.
- R14: Every offered pair has exactly one of `iss_we` and `iss_zero` set, and `iss_zero` is only ever set in zeroing mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop (ignored while busy) |
| vl | input | 7 | Vector length |
| src_step_in | input | 7 | Stored source step to start from |
| dst_step_in | input | 7 | Stored destination step to start from |
| src_mode | input | 3 | Source mask mode code |
| dst_mode | input | 3 | Destination mask mode code |
| src_reg | input | 64 | Register value for the source mask |
| dst_reg | input | 64 | Register value for the destination mask |
| cr_eq | input | 128 | Equal bits of the condition field array |
| src_cr_base | input | 7 | First condition field for the source mask |
| dst_cr_base | input | 7 | First condition field for the destination mask |
| zero_dst | input | 1 | Destination zeroing mode |
| dst_scalar | input | 1 | Destination is scalar: stop after one pair |
| pause | input | 1 | Stop at an operation boundary |
| iss_valid | output | 1 | Pair offered |
| iss_ready | input | 1 | Pair accepted when high with valid |
| iss_src_idx | output | 7 | Source element index |
| iss_dst_idx | output | 7 | Destination element index |
| iss_we | output | 1 | Write the computed result |
| iss_zero | output | 1 | Write zero to the destination |
| busy | output | 1 | Loop running |
| done | output | 1 | One-cycle pulse at loop end |
| src_step_out | output | 7 | Current source step |
| dst_step_out | output | 7 | Current destination step |

## Verification
Directed mask pairs separate the main behaviours. A twin mask checks the independent skips and the early end with enabled elements left over. A source-only mask and a destination-only mask tell compress apart from expand. A zeroing mask whose first bit is off shows that the zero slot keeps the source step. The one-hot and condition-field cases reach each mask mode. Nonzero stored steps, a vector length of zero, a scalar destination and a pause in the middle followed by a restart cover the ways a loop can begin and end. One run with alternating ready checks that back-pressure changes neither the pair sequence nor the order.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    PM_ALL    = 3'd0,
    PM_REG    = 3'd1,
    PM_NREG   = 3'd2,
    PM_ONEHOT = 3'd3,
    PM_CREQ   = 3'd4,
    PM_CRNE   = 3'd5
  } pmode_e;
endpackage

// File: rtl/vseq_mask_gen.sv
module vseq_mask_gen
  import vseq_pkg::*;
#(
  parameter int IW    = 7,
  parameter int XLEN  = 64,
  parameter int NCR   = 128,
  parameter int ELEMS = 1 << IW
) (
  input  logic [2:0]       mode,
  input  logic [XLEN-1:0]  reg_val,
  input  logic [NCR-1:0]   cr_eq,
  input  logic [IW-1:0]    cr_base,
  output logic [ELEMS-1:0] mask
);
  logic [ELEMS-1:0] reg_ext;
  logic [ELEMS-1:0] cr_mask;
  logic             oh_inrange;

  assign reg_ext    = ELEMS'(reg_val);
  assign oh_inrange = reg_val < XLEN'(ELEMS);

  // condition-field gather: element i reads field base+i
  always_comb begin
    cr_mask = '0;
    for (int i = 0; i < ELEMS; i++) begin
      if (int'(cr_base) + i < NCR) cr_mask[i] = cr_eq[int'(cr_base) + i];
    end
  end

  always_comb begin
    unique case (mode)
      PM_REG:    mask = reg_ext;
      PM_NREG:   mask = ELEMS'(~reg_val);
      PM_ONEHOT: mask = oh_inrange ? (ELEMS'(1) << reg_val[IW-1:0]) : '0;
      PM_CREQ:   mask = cr_mask;
      PM_CRNE: begin
        mask = '0;
        for (int i = 0; i < ELEMS; i++) begin
          if (int'(cr_base) + i < NCR) mask[i] = ~cr_mask[i];
        end
      end
      default:   mask = '1;
    endcase
  end
endmodule

// File: rtl/vseq_find_next.sv
module vseq_find_next #(
  parameter int ELEMS = 128,
  parameter int PW    = 8
) (
  input  logic [ELEMS-1:0] mask,
  input  logic [PW-1:0]    from,
  output logic [PW-1:0]    pos
);
  // lowest set bit at or above 'from'; ELEMS when none
  always_comb begin
    pos = PW'(ELEMS);
    for (int i = ELEMS - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) pos = PW'(i);
    end
  end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int VLW  = 7,
  parameter int XLEN = 64,
  parameter int NCR  = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [VLW-1:0]  src_step_in,
  input  logic [VLW-1:0]  dst_step_in,
  input  logic [2:0]      src_mode,
  input  logic [2:0]      dst_mode,
  input  logic [XLEN-1:0] src_reg,
  input  logic [XLEN-1:0] dst_reg,
  input  logic [NCR-1:0]  cr_eq,
  input  logic [VLW-1:0]  src_cr_base,
  input  logic [VLW-1:0]  dst_cr_base,
  input  logic            zero_dst,
  input  logic            dst_scalar,
  input  logic            pause,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [VLW-1:0]  iss_src_idx,
  output logic [VLW-1:0]  iss_dst_idx,
  output logic            iss_we,
  output logic            iss_zero,
  output logic            busy,
  output logic            done,
  output logic [VLW-1:0]  src_step_out,
  output logic [VLW-1:0]  dst_step_out
);
  localparam int ELEMS = 1 << VLW;
  localparam int PW    = VLW + 1;

  logic             running;
  logic [VLW-1:0]   vl_q, sstep, dstep;
  logic [ELEMS-1:0] smask_q, dmask_q, smask_d, dmask_d;
  logic             zero_q, scalar_q, done_q;
  logic [PW-1:0]    s_pos, d_scan, d_pos;
  logic             zslot, fin, hs;

  // one mask builder and one scanner per side
  vseq_mask_gen #(.IW(VLW), .XLEN(XLEN), .NCR(NCR), .ELEMS(ELEMS)) u_smask (
    .mode(src_mode), .reg_val(src_reg), .cr_eq(cr_eq),
    .cr_base(src_cr_base), .mask(smask_d));
  vseq_mask_gen #(.IW(VLW), .XLEN(XLEN), .NCR(NCR), .ELEMS(ELEMS)) u_dmask (
    .mode(dst_mode), .reg_val(dst_reg), .cr_eq(cr_eq),
    .cr_base(dst_cr_base), .mask(dmask_d));

  vseq_find_next #(.ELEMS(ELEMS), .PW(PW)) u_sfind (
    .mask(smask_q), .from({1'b0, sstep}), .pos(s_pos));
  vseq_find_next #(.ELEMS(ELEMS), .PW(PW)) u_dfind (
    .mask(dmask_q), .from({1'b0, dstep}), .pos(d_scan));

  // zeroing mode never skips a destination slot
  assign d_pos = zero_q ? {1'b0, dstep} : d_scan;
  assign zslot = zero_q & ~dmask_q[dstep];
  assign fin   = (s_pos >= {1'b0, vl_q}) | (d_pos >= {1'b0, vl_q});

  assign iss_valid    = running & ~fin & ~pause;
  assign hs           = iss_valid & iss_ready;
  assign iss_src_idx  = s_pos[VLW-1:0];
  assign iss_dst_idx  = d_pos[VLW-1:0];
  assign iss_zero     = zslot;
  assign iss_we       = ~zslot;
  assign busy         = running;
  assign done         = done_q;
  assign src_step_out = sstep;
  assign dst_step_out = dstep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      done_q   <= 1'b0;
      vl_q     <= '0;
      sstep    <= '0;
      dstep    <= '0;
      smask_q  <= '0;
      dmask_q  <= '0;
      zero_q   <= 1'b0;
      scalar_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!running) begin
        if (start) begin
          running  <= 1'b1;
          vl_q     <= vl;
          sstep    <= src_step_in;
          dstep    <= dst_step_in;
          smask_q  <= smask_d;
          dmask_q  <= dmask_d;
          zero_q   <= zero_dst;
          scalar_q <= dst_scalar;
        end
      end else if (fin) begin
        running <= 1'b0;
        done_q  <= 1'b1;
        sstep   <= '0;
        dstep   <= '0;
      end else if (pause) begin
        running <= 1'b0;
      end else if (hs) begin
        if (scalar_q) begin
          running <= 1'b0;
          done_q  <= 1'b1;
          sstep   <= '0;
          dstep   <= '0;
        end else begin
          dstep <= d_pos[VLW-1:0] + VLW'(1);
          sstep <= zslot ? s_pos[VLW-1:0] : s_pos[VLW-1:0] + VLW'(1);
        end
      end
    end
  end

  // ---------------- assertions ----------------
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !iss_valid);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && src_step_out == '0 && dst_step_out == '0));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_dst_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !dst_scalar && !scalar_q) |=>
      dst_step_out == $past(iss_dst_idx) + VLW'(1));

  a_r7_zero_keeps_src: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_zero && !scalar_q) |=>
      src_step_out == $past(iss_src_idx));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> pause ||
      (iss_valid && $stable(iss_src_idx) && $stable(iss_dst_idx) && $stable(iss_zero)));

  a_r14_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> $countones({iss_we, iss_zero}) == 1);

  a_r14_zero_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_zero) |-> zero_q);

  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_src_idx < vl_q && iss_dst_idx < vl_q));

  a_r12_pause_stops: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> !iss_valid);
endmodule

// File: tb/sim_vec_elem_seq.sv
module sim_vec_elem_seq;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         start = 0;
  logic [6:0]   vl = '0, src_step_in = '0, dst_step_in = '0;
  logic [2:0]   src_mode = '0, dst_mode = '0;
  logic [63:0]  src_reg = '0, dst_reg = '0;
  logic [127:0] cr_eq = '0;
  logic [6:0]   src_cr_base = '0, dst_cr_base = '0;
  logic         zero_dst = 0, dst_scalar = 0, pause = 0, iss_ready = 0;
  logic         iss_valid, iss_we, iss_zero, busy, done;
  logic [6:0]   iss_src_idx, iss_dst_idx, src_step_out, dst_step_out;

  int n_tests = 0, n_fail = 0;
  int got_s[16], got_d[16], got_z[16];
  int n_got;
  bit saw_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    vl = '0; src_step_in = '0; dst_step_in = '0;
    src_mode = 3'd0; dst_mode = 3'd0; src_reg = '0; dst_reg = '0;
    cr_eq = '0; src_cr_base = '0; dst_cr_base = '0;
    zero_dst = 0; dst_scalar = 0; pause = 0;
  endtask

  // pause_at < 0: no pause; bp: alternate ready
  task automatic run_seq(input int pause_at, input bit bp);
    n_got = 0; saw_done = 0;
    @(negedge clk); start = 1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      start = 0;
      iss_ready = bp ? cyc[0] : 1'b1;
      pause = (pause_at >= 0 && n_got == pause_at);
      #1;
      if (!busy) begin saw_done = done; break; end
      if (iss_valid && iss_ready) begin
        if (n_got < 16) begin
          got_s[n_got] = iss_src_idx; got_d[n_got] = iss_dst_idx; got_z[n_got] = iss_zero;
        end
        n_got++;
      end
    end
    pause = 0; iss_ready = 0;
  endtask

  task automatic exp_pair(input int k, input int s, input int d, input int z, input string req);
    chk(got_s[k] == s, {req, " src idx"}, got_s[k], s);
    chk(got_d[k] == d, {req, " dst idx"}, got_d[k], d);
    chk(got_z[k] == z, {req, " zero flag"}, got_z[k], z);
  endtask

  task automatic exp_end(input int n, input string req);
    chk(n_got == n, {req, " pair count"}, n_got, n);
    chk(saw_done, {req, " done"}, saw_done, 1);
    chk(src_step_out == 0 && dst_step_out == 0, {req, " steps cleared"},
        {src_step_out, dst_step_out}, 0);
    @(negedge clk); #1;
    chk(!done, "R5 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !iss_valid && !done, "R1 idle outputs", {busy, iss_valid, done}, 0);
    chk(src_step_out == 0 && dst_step_out == 0, "R1 steps zero",
        {src_step_out, dst_step_out}, 0);
  endtask

  task automatic t_twin();  // R2 R5 R8: reg vs complement
    clear_cfg(); vl = 3; src_mode = 3'd1; src_reg = 64'b101;
    dst_mode = 3'd2; dst_reg = 64'b101;
    run_seq(-1, 0);
    exp_pair(0, 0, 1, 0, "R2");
    exp_end(1, "R5");
  endtask

  task automatic t_compress();  // R3
    clear_cfg(); vl = 3; src_mode = 3'd1; src_reg = 64'b101;
    run_seq(-1, 0);
    exp_pair(0, 0, 0, 0, "R3"); exp_pair(1, 2, 1, 0, "R3");
    exp_end(2, "R3");
  endtask

  task automatic t_expand();  // R4
    clear_cfg(); vl = 3; dst_mode = 3'd1; dst_reg = 64'b101;
    run_seq(-1, 0);
    exp_pair(0, 0, 0, 0, "R4"); exp_pair(1, 1, 2, 0, "R4");
    exp_end(2, "R4");
  endtask

  task automatic t_zero();  // R7 R13 with back-pressure
    clear_cfg(); vl = 3; dst_mode = 3'd1; dst_reg = 64'b110; zero_dst = 1;
    run_seq(-1, 1);
    exp_pair(0, 0, 0, 1, "R7"); exp_pair(1, 0, 1, 0, "R7"); exp_pair(2, 1, 2, 0, "R13");
    exp_end(3, "R7");
  endtask

  task automatic t_onehot();  // R8
    clear_cfg(); vl = 3; src_mode = 3'd3; src_reg = 64'd2;
    dst_mode = 3'd1; dst_reg = 64'b010;
    run_seq(-1, 0);
    exp_pair(0, 2, 1, 0, "R8");
    exp_end(1, "R8");
  endtask

  task automatic t_cr();  // R9
    clear_cfg(); vl = 2; cr_eq[4] = 1'b1;
    src_mode = 3'd5; src_cr_base = 7'd4; dst_mode = 3'd4; dst_cr_base = 7'd4;
    run_seq(-1, 0);
    exp_pair(0, 1, 0, 0, "R9");
    exp_end(1, "R9");
  endtask

  task automatic t_resume();  // R10
    clear_cfg(); vl = 4; src_mode = 3'd1; src_reg = 64'b0101;
    dst_mode = 3'd2; dst_reg = 64'b0101; src_step_in = 7'd1; dst_step_in = 7'd2;
    run_seq(-1, 0);
    exp_pair(0, 2, 3, 0, "R10");
    exp_end(1, "R10");
  endtask

  task automatic t_vl0();  // R6
    clear_cfg(); vl = 0;
    run_seq(-1, 0);
    exp_end(0, "R6");
  endtask

  task automatic t_scalar();  // R11
    clear_cfg(); vl = 3; dst_scalar = 1;
    run_seq(-1, 0);
    exp_pair(0, 0, 0, 0, "R11");
    exp_end(1, "R11");
  endtask

  task automatic t_pause();  // R12
    clear_cfg(); vl = 4;
    run_seq(2, 0);
    chk(n_got == 2, "R12 pairs before pause", n_got, 2);
    chk(!saw_done, "R12 no done on pause", saw_done, 0);
    chk(src_step_out == 2 && dst_step_out == 2, "R12 saved steps",
        {src_step_out, dst_step_out}, {7'd2, 7'd2});
    src_step_in = src_step_out; dst_step_in = dst_step_out;
    run_seq(-1, 0);
    exp_pair(0, 2, 2, 0, "R12"); exp_pair(1, 3, 3, 0, "R12");
    exp_end(2, "R12");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_twin();
    t_compress();
    t_expand();
    t_zero();
    t_onehot();
    t_cr();
    t_resume();
    t_vl0();
    t_scalar();
    t_pause();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule